// File: doc/BRIEF.md
# Flash Read Wait-State and Prefetch Accelerator

This block sits between a CPU fetch port and a slow flash array and decides how many cycles each read costs. A two-bit wait-mode input chooses among a zero-wait direct path, a slow direct path with a fixed wait count, and an accelerator path. The accelerator checks two line buffers before it goes to the array. The first is a small trace buffer of recently missed lines. The second is a one-line prefetch buffer, which is loaded in the background with the line that follows the last one used. A separate three-bit sync-down input adds extra wait cycles to every demand access that reaches the array. A fixed-latency flash array model is part of the block and stands in for the memory.

Requests and responses are valid/ready streams. A request is taken in the cycle where `req_valid` and `req_ready` are both high. Only one request is in flight at a time. `req_ready` stays low from acceptance until the response has been consumed and any background prefetch has finished. A response stays on `rsp_valid`/`rsp_data`, unchanged, until the cycle where `rsp_ready` is high. The configuration inputs are plain levels and are meant to change only while `req_ready` is high.

Top module: `flash_read_accel`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request is accepted when `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the response is consumed. While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid` stays 1 and `rsp_data` does not change.
- R3: With wait mode 2'b00, every read goes to the array with no buffer lookup. `rsp_valid` rises 3 + S cycles after acceptance, where S is the sync-down code.
- R4: With wait mode 2'b10, and with the reserved code 2'b01 (which is treated the same way), every read goes to the array. `rsp_valid` rises 3 + SLOW_WAIT + S cycles after acceptance (7 with the defaults and S = 0).
- R5: With wait mode 2'b11, a read that misses both buffers responds 3 + ACC_MISS_WAIT + S cycles after acceptance (7 with the defaults and S = 0).
- R6: With wait mode 2'b11, a read that hits the trace buffer or the prefetch buffer responds 1 cycle after acceptance, whatever the sync-down code.
- R7: With wait mode 2'b11, the prefetch buffer needs no enable. After a miss, and after a prefetch hit, the controller loads the next sequential line in the background. A following read anywhere in that line therefore hits.
- R8: The trace buffer is looked up and filled only while `cfg_trace_en` is 1. Clearing `cfg_trace_en` empties it. It holds TRACE_LINES lines, filled on array misses and replaced in round-robin order starting from entry 0.
- R9: Any change of `cfg_wait_mode` empties both buffers, so the next read of a previously buffered line is a miss.
- R10: The sync-down code S (3'b000 adds 0 cycles, 3'b001 adds 1, and so on up to 7) is added only to demand array accesses, never to buffer hits or background prefetches.
- R11: Lines are 16 bytes. `req_addr[3:2]` selects the 32-bit word within the line, and `req_addr[19:4]` is the line tag. The array holds, at byte address a with w = a[19:2], the word {14'b0, w} ^ {w[15:0] ^ 16'h5A3C, 16'h0000}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wait_mode | input | 2 | Wait-mode select: 00 fast direct, 01 reserved, 10 slow direct, 11 accelerator |
| cfg_trace_en | input | 1 | Trace buffer enable |
| cfg_sync_down | input | 3 | Extra wait cycles on demand array accesses |
| req_valid | input | 1 | Fetch request valid |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | ADDR_W | Byte address of the fetch |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Consumer takes the read data |
| rsp_data | output | WORD_W | Read data word |

## Verification
The bench uses the default parameters: ADDR_W 20, 128-bit lines, TRACE_LINES 4, SLOW_WAIT 4 and ACC_MISS_WAIT 4. With only four trace entries, five non-sequential misses are enough to force an eviction, so the round-robin replacement can be observed at the ports. The equal slow-direct and accelerator-miss costs of 7 cycles keep the expected latencies simple, while the 1-cycle hits and the 3-cycle fast path stay clearly separate. Sync-down codes 1 and 2 are applied on both the direct and accelerator paths to show that they add cycles to array reads and never to hits.

// File: rtl/flash_accel_pkg.sv
package flash_accel_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_ARR  = 2'd2,
    ST_PF   = 2'd3
  } fsm_t;

  localparam logic [1:0] MODE_FAST  = 2'b00;
  localparam logic [1:0] MODE_RSVD  = 2'b01;
  localparam logic [1:0] MODE_SLOW  = 2'b10;
  localparam logic [1:0] MODE_ACCEL = 2'b11;
endpackage

// File: rtl/flash_array_model.sv
module flash_array_model #(
  parameter int TAG_W  = 16,
  parameter int LINE_W = 128,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic [TAG_W-1:0]  line_addr,
  output logic [LINE_W-1:0] line_q
);
  localparam int WPL  = LINE_W / WORD_W;
  localparam int WSEL = $clog2(WPL);
  localparam int WI_W = TAG_W + WSEL;

  logic [LINE_W-1:0] line_d;

  // content is a pure function of the word index, one lane per word
  for (genvar j = 0; j < WPL; j++) begin : g_lane
    logic [WI_W-1:0] wi;
    logic [31:0]     word;
    assign wi   = {line_addr, WSEL'(j)};
    assign word = 32'(wi) ^ {16'(wi) ^ 16'h5A3C, 16'h0000};
    assign line_d[j*WORD_W +: WORD_W] = WORD_W'(word);
  end

  // one fixed cycle of array latency
  always_ff @(posedge clk) begin
    line_q <= line_d;
  end
endmodule

// File: rtl/flash_trace_buf.sv
module flash_trace_buf #(
  parameter int TAG_W  = 16,
  parameter int LINE_W = 128,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              hit,
  output logic [LINE_W-1:0] hit_line,
  input  logic              fill_en,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [LINE_W-1:0] fill_line,
  output logic              any_valid
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]  vld;
  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [LINE_W-1:0] data_q [DEPTH];
  logic [PW-1:0]     ptr;
  logic [DEPTH-1:0]  match;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match[i] = vld[i] && (tag_q[i] == lk_tag);
  end

  always_comb begin
    hit_line = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match[i]) hit_line = data_q[i];
    end
  end

  assign hit       = |match;
  assign any_valid = |vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      ptr <= '0;
    end else if (clear) begin
      vld <= '0;
      ptr <= '0;
    end else if (fill_en) begin
      vld[ptr] <= 1'b1;
      ptr      <= (int'(ptr) == DEPTH - 1) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !clear) begin
      tag_q[ptr]  <= fill_tag;
      data_q[ptr] <= fill_line;
    end
  end
endmodule

// File: rtl/flash_pf_buf.sv
module flash_pf_buf #(
  parameter int TAG_W  = 16,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              hit,
  output logic [LINE_W-1:0] line,
  input  logic              fill_en,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [LINE_W-1:0] fill_line,
  output logic              valid
);
  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      tag_q <= '0;
    end else if (clear) begin
      valid <= 1'b0;
    end else if (fill_en) begin
      valid <= 1'b1;
      tag_q <= fill_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !clear) line <= fill_line;
  end

  assign hit = valid && (tag_q == lk_tag);
endmodule

// File: rtl/flash_read_accel.sv
module flash_read_accel
  import flash_accel_pkg::*;
#(
  parameter int ADDR_W        = 20,
  parameter int LINE_W        = 128,
  parameter int WORD_W        = 32,
  parameter int TRACE_LINES   = 4,
  parameter int SLOW_WAIT     = 4,
  parameter int ACC_MISS_WAIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_wait_mode,
  input  logic              cfg_trace_en,
  input  logic [2:0]        cfg_sync_down,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_data
);
  localparam int OFS_W = $clog2(LINE_W / 8);
  localparam int WSEL  = $clog2(LINE_W / WORD_W);
  localparam int TAG_W = ADDR_W - OFS_W;
  localparam int CNT_W = $clog2(SLOW_WAIT + ACC_MISS_WAIT + 10) + 1;
  localparam logic [CNT_W-1:0] PF_START = CNT_W'(ACC_MISS_WAIT + 1);

  fsm_t              state;
  logic [TAG_W-1:0]  tag_q;
  logic [WSEL-1:0]   wsel_q;
  logic [CNT_W-1:0]  cnt;
  logic [TAG_W-1:0]  arr_tag;
  logic [1:0]        mode_q;
  logic [LINE_W-1:0] line_q;

  logic              accel, mode_chg;
  logic [CNT_W-1:0]  base_wait, demand_start;
  logic              tr_hit, pf_hit, use_tr, use_pf;
  logic [LINE_W-1:0] tr_line, pf_line;
  logic              tr_fill, pf_fill, tr_clear;
  logic              pf_valid, tr_any_valid;
  logic              unused_lsb;

  assign unused_lsb = ^req_addr[OFS_W-WSEL-1:0];

  function automatic logic [WORD_W-1:0] pick(input logic [LINE_W-1:0] l,
                                             input logic [WSEL-1:0] s);
    return l[s*WORD_W +: WORD_W];
  endfunction

  assign accel    = (cfg_wait_mode == MODE_ACCEL);
  assign mode_chg = (cfg_wait_mode != mode_q);
  assign tr_clear = mode_chg || !cfg_trace_en;

  always_comb begin
    unique case (cfg_wait_mode)
      MODE_FAST:  base_wait = '0;
      MODE_ACCEL: base_wait = CNT_W'(ACC_MISS_WAIT);
      default:    base_wait = CNT_W'(SLOW_WAIT);
    endcase
  end

  assign demand_start = base_wait + CNT_W'(cfg_sync_down) + 1'b1;

  assign use_tr  = accel && cfg_trace_en && tr_hit;
  assign use_pf  = accel && pf_hit;
  assign tr_fill = (state == ST_ARR) && (cnt == '0) && accel && cfg_trace_en;
  assign pf_fill = (state == ST_PF) && (cnt == '0);

  assign req_ready = (state == ST_IDLE) && !rsp_valid;

  flash_array_model #(.TAG_W(TAG_W), .LINE_W(LINE_W), .WORD_W(WORD_W)) u_arr (
    .clk      (clk),
    .line_addr(arr_tag),
    .line_q   (line_q)
  );

  flash_trace_buf #(.TAG_W(TAG_W), .LINE_W(LINE_W), .DEPTH(TRACE_LINES)) u_trace (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (tr_clear),
    .lk_tag   (tag_q),
    .hit      (tr_hit),
    .hit_line (tr_line),
    .fill_en  (tr_fill),
    .fill_tag (tag_q),
    .fill_line(line_q),
    .any_valid(tr_any_valid)
  );

  flash_pf_buf #(.TAG_W(TAG_W), .LINE_W(LINE_W)) u_pf (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (mode_chg),
    .lk_tag   (tag_q),
    .hit      (pf_hit),
    .line     (pf_line),
    .fill_en  (pf_fill),
    .fill_tag (arr_tag),
    .fill_line(line_q),
    .valid    (pf_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      tag_q     <= '0;
      wsel_q    <= '0;
      cnt       <= '0;
      arr_tag   <= '0;
      mode_q    <= MODE_ACCEL;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      mode_q <= cfg_wait_mode;
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid && req_ready) begin
            tag_q  <= req_addr[ADDR_W-1:OFS_W];
            wsel_q <= req_addr[OFS_W-1:OFS_W-WSEL];
            state  <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (use_tr) begin
            rsp_data  <= pick(tr_line, wsel_q);
            rsp_valid <= 1'b1;
            state     <= ST_IDLE;
          end else if (use_pf) begin
            rsp_data  <= pick(pf_line, wsel_q);
            rsp_valid <= 1'b1;
            arr_tag   <= tag_q + 1'b1;
            cnt       <= PF_START;
            state     <= ST_PF;
          end else begin
            arr_tag <= tag_q;
            cnt     <= demand_start;
            state   <= ST_ARR;
          end
        end
        ST_ARR: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            rsp_data  <= pick(line_q, wsel_q);
            rsp_valid <= 1'b1;
            if (accel) begin
              arr_tag <= tag_q + 1'b1;
              cnt     <= PF_START;
              state   <= ST_PF;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_PF: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else           state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_read_accel_chk.sv
module flash_read_accel_chk #(
  parameter int WORD_W        = 32,
  parameter int SLOW_WAIT     = 4,
  parameter int ACC_MISS_WAIT = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cfg_wait_mode,
  input logic [1:0]        mode_q,
  input logic              cfg_trace_en,
  input logic [2:0]        cfg_sync_down,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [WORD_W-1:0] rsp_data,
  input logic              pf_valid,
  input logic              tr_any_valid
);
  logic [7:0] lat;
  logic       busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat  <= '0;
      busy <= 1'b0;
    end else if (req_valid && req_ready) begin
      lat  <= '0;
      busy <= 1'b1;
    end else if (busy) begin
      if (rsp_valid)          busy <= 1'b0;
      else if (lat != 8'hFF)  lat  <= lat + 1'b1;
    end
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  assert_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  assert_fast_lat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) && cfg_wait_mode == 2'b00 |-> int'(lat) == 3 + int'(cfg_sync_down));

  assert_slow_lat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) && (cfg_wait_mode == 2'b01 || cfg_wait_mode == 2'b10)
    |-> int'(lat) == 3 + SLOW_WAIT + int'(cfg_sync_down));

  assert_accel_lat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) && cfg_wait_mode == 2'b11
    |-> int'(lat) == 1 || int'(lat) == 3 + ACC_MISS_WAIT + int'(cfg_sync_down));

  assert_trace_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_trace_en |=> !tr_any_valid);

  assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wait_mode != mode_q |=> !pf_valid && !tr_any_valid);
endmodule

bind flash_read_accel flash_read_accel_chk #(
  .WORD_W(WORD_W), .SLOW_WAIT(SLOW_WAIT), .ACC_MISS_WAIT(ACC_MISS_WAIT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_wait_mode(cfg_wait_mode),
  .mode_q       (mode_q),
  .cfg_trace_en (cfg_trace_en),
  .cfg_sync_down(cfg_sync_down),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_data     (rsp_data),
  .pf_valid     (pf_valid),
  .tr_any_valid (tr_any_valid)
);

// File: tb/sim_flash_read_accel.sv
`timescale 1ns/1ps
module sim_flash_read_accel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_wait_mode = 2'b11;
  logic        cfg_trace_en = 1'b0;
  logic [2:0]  cfg_sync_down = 3'd0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_data;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  localparam int L_FAST = 3;
  localparam int L_SLOW = 7;
  localparam int L_MISS = 7;
  localparam int L_HIT  = 1;

  always #2.5 clk = ~clk;

  flash_read_accel u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wait_mode(cfg_wait_mode),
    .cfg_trace_en(cfg_trace_en), .cfg_sync_down(cfg_sync_down),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  function automatic logic [31:0] exp_word(input logic [19:0] a);
    logic [17:0] w;
    w = a[19:2];
    return {14'b0, w} ^ {w[15:0] ^ 16'h5A3C, 16'h0000};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [1:0] m, input logic te, input logic [2:0] sd);
    @(negedge clk);
    for (int g = 0; g < 200 && !req_ready; g++) @(negedge clk);
    cfg_wait_mode = m;
    cfg_trace_en  = te;
    cfg_sync_down = sd;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_read(input logic [19:0] a, input int exp_lat, input int hold,
                         input string rq);
    int lat;
    logic [31:0] first;
    bit stable_ok;
    @(negedge clk);
    for (int g = 0; g < 200 && !req_ready; g++) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    if (hold > 0) chk(!req_ready, "R2", "req_ready while busy", req_ready, 0);
    lat = 0;
    while (!rsp_valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == exp_lat, rq, $sformatf("latency @%05h", a), lat, exp_lat);
    chk(rsp_data == exp_word(a), "R11", $sformatf("data @%05h", a), rsp_data, exp_word(a));
    first = rsp_data;
    stable_ok = 1'b1;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      if (!rsp_valid || rsp_data != first) stable_ok = 1'b0;
    end
    if (hold > 0) chk(stable_ok, "R2", "response held under back-pressure", rsp_data, first);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
  endtask

  task automatic t_direct_fast;   // R3
    set_cfg(2'b00, 1'b0, 3'd0);
    do_read(20'h01234, L_FAST, 0, "R3");
    do_read(20'h01234, L_FAST, 0, "R3");
    do_read(20'h0123C, L_FAST, 0, "R3");
  endtask

  task automatic t_direct_slow;   // R4
    set_cfg(2'b10, 1'b0, 3'd0);
    do_read(20'h02000, L_SLOW, 0, "R4");
    set_cfg(2'b01, 1'b0, 3'd0);
    do_read(20'h02010, L_SLOW, 0, "R4");
  endtask

  task automatic t_prefetch;      // R5 R7 R8
    set_cfg(2'b11, 1'b0, 3'd0);
    do_read(20'h03000, L_MISS, 0, "R5");
    do_read(20'h03000, L_MISS, 0, "R8");
    do_read(20'h03014, L_HIT, 0, "R7");
    do_read(20'h03028, L_HIT, 0, "R7");
  endtask

  task automatic t_trace;         // R6 R8
    set_cfg(2'b11, 1'b1, 3'd0);
    do_read(20'h04008, L_MISS, 0, "R5");
    do_read(20'h0400C, L_HIT, 0, "R6");
    do_read(20'h04000, L_HIT, 0, "R6");
  endtask

  task automatic t_trace_depth;   // R8
    set_cfg(2'b11, 1'b0, 3'd0);
    set_cfg(2'b11, 1'b1, 3'd0);
    do_read(20'h05000, L_MISS, 0, "R8");
    do_read(20'h05100, L_MISS, 0, "R8");
    do_read(20'h05200, L_MISS, 0, "R8");
    do_read(20'h05300, L_MISS, 0, "R8");
    do_read(20'h05204, L_HIT, 0, "R8");
    do_read(20'h05400, L_MISS, 0, "R8");
    do_read(20'h05000, L_MISS, 0, "R8");
    set_cfg(2'b11, 1'b0, 3'd0);
    set_cfg(2'b11, 1'b1, 3'd0);
    do_read(20'h05100, L_MISS, 0, "R8");
  endtask

  task automatic t_sync;          // R10
    set_cfg(2'b00, 1'b0, 3'd1);
    do_read(20'h06000, L_FAST + 1, 0, "R10");
    set_cfg(2'b11, 1'b0, 3'd2);
    do_read(20'h07000, L_MISS + 2, 0, "R10");
    do_read(20'h07010, L_HIT, 0, "R10");
    set_cfg(2'b11, 1'b0, 3'd0);
  endtask

  task automatic t_invalidate;    // R9
    set_cfg(2'b11, 1'b1, 3'd0);
    do_read(20'h08000, L_MISS, 0, "R9");
    do_read(20'h08004, L_HIT, 0, "R9");
    set_cfg(2'b00, 1'b1, 3'd0);
    set_cfg(2'b11, 1'b1, 3'd0);
    do_read(20'h08004, L_MISS, 0, "R9");
    do_read(20'h09000, L_MISS, 0, "R9");
    set_cfg(2'b10, 1'b1, 3'd0);
    set_cfg(2'b11, 1'b1, 3'd0);
    do_read(20'h09010, L_MISS, 0, "R9");
  endtask

  task automatic t_backpressure;  // R2
    set_cfg(2'b11, 1'b0, 3'd0);
    do_read(20'h0A008, L_MISS, 5, "R2");
    do_read(20'h0A01C, L_HIT, 3, "R2");
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_direct_fast();
    t_direct_slow();
    t_prefetch();
    t_trace();
    t_trace_depth();
    t_sync();
    t_invalidate();
    t_backpressure();
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule